// File: doc/BRIEF.md
# Seconds Countdown Alarm

This block is a relative alarm timer for a real-time-clock domain. Software loads a number of seconds into a load register. Once the counter is enabled, each one-second tick lowers the current count by one. When the count goes from one to zero, a sticky pending flag is set and the count stays at zero. The pending flag drives a level interrupt, gated by an interrupt enable. It also drives a wakeup line, gated by a routing bit. Software clears the flag by writing a one to it.

A weekly wall-clock alarm sits beside the countdown. Its compare logic lives elsewhere and reaches this block as a single match strobe. Here only its enable, its interrupt enable and its write-one-to-clear pending flag are kept. Both alarms share one interrupt line.

Registers sit on a simple write-strobe bus with a combinational read port. The byte offsets are fixed because software decodes them. Every register field used is bit 0, except the load and count values, which use the full width.

Top module: `sec_countdown_alarm`

## Requirements
- R1: After reset, every register reads 0, and `irq` and `wakeup` are low.
- R2: A write to offset 0x20 stores the value there and copies it into the current count at 0x24 on the next cycle. This happens whether the counter is enabled or not.
- R3: When bit 0 of 0x28 is 1, each `tick` cycle lowers a nonzero count by exactly one. The count holds in cycles without a tick, and it holds while the enable is 0.
- R4: A tick that takes the enabled count from 1 to 0 sets the pending bit (bit 0 of 0x30). After that the count stays at 0 until the next load.
- R5: Writing 0 to 0x20 clears the countdown, and ticks on a zero count never set the pending bit.
- R6: Writing 1 to bit 0 of 0x30 clears the pending bit, and writing 0 there leaves it unchanged.
- R7: When an expiry and a clear of 0x30 fall in the same cycle, the pending bit stays set.
- R8: `irq` = (pending AND bit 0 of 0x2C) OR (weekly pending AND bit 0 of 0x48).
- R9: `wakeup` = pending AND bit 0 of 0x50.
- R10: `weekMatch` sets the weekly pending bit (bit 0 of 0x4C) only when bit 0 of 0x44 is 1. A 1 written to bit 0 of 0x4C clears it, and a match in the same cycle wins over the clear.
- R11: A load write in a tick cycle takes the written value, with no decrement applied.
- R12: Offsets outside the map read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle pulse once per second |
| weekMatch | input | 1 | One-cycle strobe from the weekly compare logic |
| wrEn | input | 1 | Register write strobe |
| addr | input | 8 | Register byte offset |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data for `addr` (combinational) |
| irq | output | 1 | Level interrupt |
| wakeup | output | 1 | Wakeup request |

## Verification
Assertions check on every cycle that the count steps down by exactly one per enabled tick and holds otherwise, and that a load takes the written value. They also check that zero is sticky, that expiry sets the pending bit even against a same-cycle clear, and that unmapped writes leave the configuration alone. The bench scenarios show the software-visible results: register readback, how the two alarms combine on one interrupt line, the wakeup routing, and the ordering cases where a load meets a tick or a clear meets an expiry. The bench compares each cycle against a reference model that takes random bus traffic, ticks and weekly matches.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
  localparam int ADDR_W = 8;

  // Register byte offsets (software decodes these)
  localparam logic [ADDR_W-1:0] OFF_LOAD      = 8'h20;
  localparam logic [ADDR_W-1:0] OFF_COUNT     = 8'h24;
  localparam logic [ADDR_W-1:0] OFF_CNT_EN    = 8'h28;
  localparam logic [ADDR_W-1:0] OFF_IRQ_EN    = 8'h2C;
  localparam logic [ADDR_W-1:0] OFF_PEND      = 8'h30;
  localparam logic [ADDR_W-1:0] OFF_WK_EN     = 8'h44;
  localparam logic [ADDR_W-1:0] OFF_WK_IRQ_EN = 8'h48;
  localparam logic [ADDR_W-1:0] OFF_WK_PEND   = 8'h4C;
  localparam logic [ADDR_W-1:0] OFF_WAKE      = 8'h50;

  // Index of each single-bit configuration register
  localparam int CFG_CNT_EN    = 0;
  localparam int CFG_IRQ_EN    = 1;
  localparam int CFG_WAKE      = 2;
  localparam int CFG_WK_EN     = 3;
  localparam int CFG_WK_IRQ_EN = 4;
  localparam int NUM_CFG       = 5;

  function automatic logic [ADDR_W-1:0] cfgOffset(input int idx);
    case (idx)
      CFG_CNT_EN:    return OFF_CNT_EN;
      CFG_IRQ_EN:    return OFF_IRQ_EN;
      CFG_WAKE:      return OFF_WAKE;
      CFG_WK_EN:     return OFF_WK_EN;
      default:       return OFF_WK_IRQ_EN;
    endcase
  endfunction

  // Strobes the control half hands to the datapath
  typedef struct packed {
    logic loadWr;     // new load value on wdata
    logic pendClr;    // write-one-to-clear of countdown pending
    logic wkPendClr;  // write-one-to-clear of weekly pending
  } alarmStrobe_t;
endpackage

// File: rtl/alarm_ctrl.sv
module alarm_ctrl
  import alarm_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output alarmStrobe_t      strobe,
  output logic [NUM_CFG-1:0] cfgQ
);

  logic mappedHit;

  // One flop per configuration bit, each with its own decoded offset
  for (genvar gi = 0; gi < NUM_CFG; gi++) begin : g_cfg
    localparam logic [ADDR_W-1:0] MY_OFF = cfgOffset(gi);
    always_ff @(posedge clk) begin
      if (!rstN) begin
        cfgQ[gi] <= 1'b0;
      end else if (wrEn && (addr == MY_OFF)) begin
        cfgQ[gi] <= wdata[0];
      end
    end
  end

  always_comb begin
    strobe           = '0;
    strobe.loadWr    = wrEn && (addr == OFF_LOAD);
    strobe.pendClr   = wrEn && (addr == OFF_PEND) && wdata[0];
    strobe.wkPendClr = wrEn && (addr == OFF_WK_PEND) && wdata[0];
  end

  always_comb begin
    mappedHit = 1'b0;
    for (int i = 0; i < NUM_CFG; i++) begin
      if (addr == cfgOffset(i)) mappedHit = 1'b1;
    end
  end

  AST_UNMAPPED_NO_CFG: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !mappedHit) |=> $stable(cfgQ)); // R12

endmodule

// File: rtl/alarm_datapath.sv
module alarm_datapath
  import alarm_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              weekMatch,
  input  alarmStrobe_t      strobe,
  input  logic [DATA_W-1:0] wdata,
  input  logic              cntEn,
  input  logic              wkEn,
  output logic [DATA_W-1:0] loadVal,
  output logic [DATA_W-1:0] curCount,
  output logic              cntPend,
  output logic              wkPend
);

  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  logic stepDown;
  logic expire;
  logic wkSet;

  assign stepDown = tick && cntEn && (curCount != '0) && !strobe.loadWr;
  assign expire   = stepDown && (curCount == ONE);
  assign wkSet    = weekMatch && wkEn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      loadVal  <= '0;
      curCount <= '0;
    end else if (strobe.loadWr) begin
      loadVal  <= wdata;
      curCount <= wdata;
    end else if (stepDown) begin
      curCount <= curCount - ONE;
    end
  end

  // Set has priority over the write-one-to-clear
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntPend <= 1'b0;
    end else if (expire) begin
      cntPend <= 1'b1;
    end else if (strobe.pendClr) begin
      cntPend <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wkPend <= 1'b0;
    end else if (wkSet) begin
      wkPend <= 1'b1;
    end else if (strobe.wkPendClr) begin
      wkPend <= 1'b0;
    end
  end

  AST_LOAD_TAKES_VALUE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadWr |=> (curCount == $past(wdata))); // R2
  AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (tick && cntEn && (curCount != '0) && !strobe.loadWr) |=> (curCount == $past(curCount) - ONE)); // R3
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rstN)
    (!tick && !strobe.loadWr) |=> $stable(curCount)); // R3
  AST_ZERO_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    ((curCount == '0) && !strobe.loadWr) |=> (curCount == '0)); // R4
  AST_EXPIRY_SETS: assert property (@(posedge clk) disable iff (!rstN)
    (tick && cntEn && (curCount == ONE) && !strobe.loadWr) |=> cntPend); // R4
  AST_SET_BEATS_CLR: assert property (@(posedge clk) disable iff (!rstN)
    (expire && strobe.pendClr) |=> cntPend); // R7
  AST_NO_SET_FROM_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (!cntPend && (curCount == '0) && !strobe.loadWr) |=> !cntPend); // R5
  AST_WEEK_GATED: assert property (@(posedge clk) disable iff (!rstN)
    (!wkPend && !(weekMatch && wkEn)) |=> !wkPend); // R10

endmodule

// File: rtl/sec_countdown_alarm.sv
module sec_countdown_alarm
  import alarm_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              weekMatch,
  input  logic              wrEn,
  input  logic [7:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq,
  output logic              wakeup
);

  alarmStrobe_t       strobe;
  logic [NUM_CFG-1:0] cfgQ;
  logic [DATA_W-1:0]  loadVal;
  logic [DATA_W-1:0]  curCount;
  logic               cntPend;
  logic               wkPend;

  alarm_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .addr   (addr),
    .wdata  (wdata),
    .strobe (strobe),
    .cfgQ   (cfgQ)
  );

  alarm_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .tick      (tick),
    .weekMatch (weekMatch),
    .strobe    (strobe),
    .wdata     (wdata),
    .cntEn     (cfgQ[CFG_CNT_EN]),
    .wkEn      (cfgQ[CFG_WK_EN]),
    .loadVal   (loadVal),
    .curCount  (curCount),
    .cntPend   (cntPend),
    .wkPend    (wkPend)
  );

  always_comb begin
    rdata = '0;
    case (addr)
      OFF_LOAD:      rdata = loadVal;
      OFF_COUNT:     rdata = curCount;
      OFF_CNT_EN:    rdata[0] = cfgQ[CFG_CNT_EN];
      OFF_IRQ_EN:    rdata[0] = cfgQ[CFG_IRQ_EN];
      OFF_PEND:      rdata[0] = cntPend;
      OFF_WK_EN:     rdata[0] = cfgQ[CFG_WK_EN];
      OFF_WK_IRQ_EN: rdata[0] = cfgQ[CFG_WK_IRQ_EN];
      OFF_WK_PEND:   rdata[0] = wkPend;
      OFF_WAKE:      rdata[0] = cfgQ[CFG_WAKE];
      default:       rdata = '0;
    endcase
  end

  assign irq    = (cntPend && cfgQ[CFG_IRQ_EN]) || (wkPend && cfgQ[CFG_WK_IRQ_EN]);
  assign wakeup = cntPend && cfgQ[CFG_WAKE];

endmodule

// File: tb/sec_countdown_alarm_bench.sv
module sec_countdown_alarm_bench;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          tick = 1'b0;
  logic          weekMatch = 1'b0;
  logic          wrEn = 1'b0;
  logic [7:0]    addr = 8'h00;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          irq;
  logic          wakeup;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // Reference state, built from the requirements
  logic [DW-1:0] mLoad = '0, mCnt = '0;
  logic mEn = 0, mIrqEn = 0, mPend = 0, mWake = 0, mWkEn = 0, mWkIrqEn = 0, mWkPend = 0;

  always #5 clk = ~clk;

  sec_countdown_alarm #(.DATA_W(DW)) u_sec_countdown_alarm (
    .clk(clk), .rstN(rstN), .tick(tick), .weekMatch(weekMatch),
    .wrEn(wrEn), .addr(addr), .wdata(wdata), .rdata(rdata),
    .irq(irq), .wakeup(wakeup)
  );

  function automatic logic [DW-1:0] modelRead(input logic [7:0] a);
    case (a)
      8'h20: return mLoad;
      8'h24: return mCnt;
      8'h28: return DW'(mEn);
      8'h2C: return DW'(mIrqEn);
      8'h30: return DW'(mPend);
      8'h44: return DW'(mWkEn);
      8'h48: return DW'(mWkIrqEn);
      8'h4C: return DW'(mWkPend);
      8'h50: return DW'(mWake);
      default: return '0; // R12
    endcase
  endfunction

  function automatic string tagFor(input logic [7:0] a);
    case (a)
      8'h20, 8'h24: return "R2";
      8'h30:        return "R4";
      8'h4C:        return "R10";
      8'h28, 8'h2C, 8'h44, 8'h48, 8'h50: return "R8";
      default:      return "R12";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Apply one cycle of stimulus; model the clock edge; return idle at negedge
  task automatic step(input bit w, input logic [7:0] a, input logic [DW-1:0] d,
                      input bit t, input bit m);
    logic expire, ldWr;
    wrEn = w; addr = a; wdata = d; tick = t; weekMatch = m;
    @(posedge clk);
    ldWr   = w && (a == 8'h20);
    expire = t && mEn && (mCnt == 1) && !ldWr;
    if (ldWr) begin mLoad = d; mCnt = d; end
    else if (t && mEn && (mCnt != 0)) mCnt = mCnt - 1;
    if (expire) mPend = 1;
    else if (w && a == 8'h30 && d[0]) mPend = 0;
    if (m && mWkEn) mWkPend = 1;
    else if (w && a == 8'h4C && d[0]) mWkPend = 0;
    if (w) begin
      case (a)
        8'h28: mEn = d[0];
        8'h2C: mIrqEn = d[0];
        8'h44: mWkEn = d[0];
        8'h48: mWkIrqEn = d[0];
        8'h50: mWake = d[0];
        default: ;
      endcase
    end
    @(negedge clk);
    wrEn = 0; tick = 0; weekMatch = 0; wdata = '0;
  endtask

  task automatic readChk(input logic [7:0] a, input string tag);
    addr = a;
    #1;
    chk(tag, rdata, modelRead(a));
    chk("R8", DW'(irq), DW'((mPend && mIrqEn) || (mWkPend && mWkIrqEn)));
    chk("R9", DW'(wakeup), DW'(mPend && mWake));
  endtask

  task automatic wr(input logic [7:0] a, input logic [DW-1:0] d);
    step(1, a, d, 0, 0);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] addrs [10] = '{8'h20, 8'h24, 8'h28, 8'h2C, 8'h30, 8'h44, 8'h48, 8'h4C, 8'h50, 8'h3C};
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1: reset state
    foreach (addrs[i]) readChk(addrs[i], "R1");
    chk("R1", DW'({irq, wakeup}), '0);

    // R2: load while disabled copies into count
    wr(8'h20, 32'd3);
    readChk(8'h24, "R2");
    chk("R2", rdata, 32'd3);
    // R3: disabled -> tick holds
    step(0, 8'h00, 0, 1, 0);
    readChk(8'h24, "R3");
    chk("R3", rdata, 32'd3);
    wr(8'h28, 1); wr(8'h2C, 1); wr(8'h50, 1);
    step(0, 8'h00, 0, 1, 0);
    step(0, 8'h00, 0, 0, 0);
    readChk(8'h24, "R3");
    chk("R3", rdata, 32'd2);
    step(0, 8'h00, 0, 1, 0);
    step(0, 8'h00, 0, 1, 0);
    // R4: expiry sets pending, irq and wakeup follow
    readChk(8'h30, "R4");
    chk("R4", rdata, 32'd1);
    chk("R8", DW'(irq), 1);
    chk("R9", DW'(wakeup), 1);
    step(0, 8'h00, 0, 1, 0);
    readChk(8'h24, "R4");
    chk("R4", rdata, 32'd0);
    // R6: write 0 no effect, write 1 clears
    wr(8'h30, 0);
    readChk(8'h30, "R6");
    chk("R6", rdata, 32'd1);
    wr(8'h30, 1);
    readChk(8'h30, "R6");
    chk("R6", rdata, 32'd0);
    chk("R8", DW'(irq), 0);
    // R7: clear in the expiry cycle loses
    wr(8'h20, 32'd1);
    step(1, 8'h30, 1, 1, 0);
    readChk(8'h30, "R7");
    chk("R7", rdata, 32'd1);
    wr(8'h30, 1);
    // R11: load in a tick cycle takes the value
    step(1, 8'h20, 32'd5, 1, 0);
    readChk(8'h24, "R11");
    chk("R11", rdata, 32'd5);
    // restart while enabled
    step(0, 8'h00, 0, 1, 0);
    wr(8'h20, 32'd9);
    readChk(8'h24, "R2");
    chk("R2", rdata, 32'd9);
    // R5: zero load, ticks never expire
    wr(8'h20, 32'd0);
    repeat (3) step(0, 8'h00, 0, 1, 0);
    readChk(8'h30, "R5");
    chk("R5", rdata, 32'd0);
    // R10: week match ignored while disabled
    step(0, 8'h00, 0, 0, 1);
    readChk(8'h4C, "R10");
    chk("R10", rdata, 32'd0);
    wr(8'h44, 1); wr(8'h48, 1);
    step(0, 8'h00, 0, 0, 1);
    readChk(8'h4C, "R10");
    chk("R10", rdata, 32'd1);
    chk("R8", DW'(irq), 1);
    step(1, 8'h4C, 1, 0, 1);
    readChk(8'h4C, "R10");
    chk("R10", rdata, 32'd1);
    wr(8'h4C, 1);
    readChk(8'h4C, "R10");
    chk("R10", rdata, 32'd0);
    // R12: unmapped write changes nothing
    wr(8'h3C, '1);
    readChk(8'h3C, "R12");
    chk("R12", rdata, 32'd0);
    foreach (addrs[i]) readChk(addrs[i], "R12");

    // Random traffic against the model
    for (int n = 0; n < 4000; n++) begin
      bit w = ($urandom_range(0, 9) < 3);
      logic [7:0] a = addrs[$urandom_range(0, 9)];
      logic [DW-1:0] d = (a == 8'h20) ? DW'($urandom_range(0, 6)) : DW'($urandom_range(0, 3));
      step(w, a, d, $urandom_range(0, 1) == 1, $urandom_range(0, 7) == 0);
      begin
        logic [7:0] ra = addrs[$urandom_range(0, 9)];
        readChk(ra, tagFor(ra));
      end
    end

    done = 1;
    summary();
    $finish;
  end
endmodule